// File: doc/BRIEF.md
# Byte-Wide NOR Flash Command Controller

This block fronts a byte-wide NOR flash array that is held in an internal single-port memory. Its host bus is asynchronous in style: an address, an 8-bit data path, and active-low chip enable, output enable and write enable, plus an active-low hardware reset. The controller samples the enable pins on its clock. A falling write enable while chip enable is low is one command write. A falling output enable while chip enable is low is one read. Command writes drive a small decoder, which starts timed program and erase operations. Counters model the pulse timing of these operations.

While an operation is running, reads return a status byte and not array data. Bit 7 is the complement of bit 7 of the data being written, and bit 6 flips on every status read. The host therefore polls until bit 7 matches its data or until bit 6 stops changing. An erase first drives every byte of the chosen sectors to 0x00 and then sets them to 0xFF. An erase can be suspended so that the other sectors can be read or programmed, and it can then be resumed. Each sector can be locked by a protection input. A temporary-unprotect input overrides the lock. A low-supply input blocks every command write.

The address width is fixed at 11 bits by the package so that the default build stays small. Setting it to 18 gives the full 256 KiB array. The seven sectors keep their proportions at any width. A bottom-boot layout (sizes in 1/32 of the array: 2, 1, 1, 4, 8, 8, 8 from address 0) is the default, and a parameter mirrors it to a top-boot layout.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: In read mode, a read strobe (falling `oeN` while `ceN` is low) loads `dataOut` with the array byte at `addr` on that clock edge, and `dataOut` holds that value until the next read strobe. `dataOut` resets to 0x00.
- R2: With `TOP_BOOT=0` and 11 address bits, the sectors are 0x000-0x07F (index 0), 0x080-0x0BF (1), 0x0C0-0x0FF (2), 0x100-0x1FF (3), 0x200-0x3FF (4), 0x400-0x5FF (5) and 0x600-0x7FF (6). Bit n of `protMask` belongs to sector index n.
- R3: The writes 0xAA at 0x555, 0x55 at 0x2AA and 0xA0 at 0x555, followed by a write of data D at address A, program A. After `PROG_CYC` cycles, A holds its old value AND D.
- R4: While an operation is running, a read returns a status byte. Bit 7 is the complement of bit 7 of the programmed data (0 during an erase). Bit 6 inverts on each status read. Bits 5..0 are 0. Array data returns once the operation ends.
- R5: The writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA and 0x10@0x555 erase every unprotected sector. Each byte is first set to 0x00 and then to 0xFF.
- R6: The same prefix ended by 0x30 at an address in a sector selects that sector. Each further 0x30 write within `WIN_CYC` cycles of the last one adds its sector. Any other write in that window cancels the erase. Sectors that are not selected are untouched.
- R7: A write of 0xB0 during an erase suspends it. While suspended, reads of unselected sectors return array data and reads of selected sectors return status. A program of an unselected sector is carried out, and a program of a selected sector is ignored. A write of 0x30 resumes the erase where it stopped.
- R8: A sector whose `protMask` bit is 1 ignores program and erase while `unprotect` is 0. While `unprotect` is 1, the lock has no effect.
- R9: While `lowSupply` is 1, no write changes the controller's state.
- R10: A write that breaks a command sequence, or a write of 0xF0, returns the controller to read mode. `rstN` low aborts any operation and returns the controller to read mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous reset, active low; aborts operations |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low; its falling edge is a read |
| weN | input | 1 | Write enable, active low; its falling edge is a write |
| addr | input | 11 | Byte address |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Read data or status byte |
| lowSupply | input | 1 | Low-supply detect; blocks all writes |
| unprotect | input | 1 | Temporary override of sector protection |
| protMask | input | 7 | Per-sector protection, bit n is sector n |

## Verification
The assertions check the following on every cycle:
- the erase engine writes only inside the selected sectors;
- a suspended controller never touches the array;
- a resume write always restarts the erase;
- a program aimed at a locked sector never leaves read mode;
- a low supply never lets an idle controller become busy;
- back-to-back status reads always flip bit 6.

Only the bench scenarios can show the rest:
- the AND rule of programming;
- the exact sector boundaries;
- accumulation and cancellation of the sector-erase window;
- programs carried out while an erase is suspended;
- the erase resuming from where it stopped;
- a reset that leaves untouched bytes intact.

// File: rtl/flash_pkg.sv
package flash_pkg;
  localparam int ADDR_W   = 11;
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int NUM_SECT = 7;
  localparam int SECT_W   = 3;
  localparam int UNIT_W   = 5;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    logic                memWe;
    logic                memAnd;
    addr_t               memAddr;
    logic [7:0]          memData;
    logic                busy;
    logic                suspended;
    logic                pollBit;
    logic [NUM_SECT-1:0] eraseSel;
  } strobe_t;

  function automatic logic [SECT_W-1:0] bottomIdx(input logic [UNIT_W-1:0] u);
    if (u < 5'd2)       return 3'd0;
    else if (u == 5'd2) return 3'd1;
    else if (u == 5'd3) return 3'd2;
    else if (u < 5'd8)  return 3'd3;
    else if (u < 5'd16) return 3'd4;
    else if (u < 5'd24) return 3'd5;
    else                return 3'd6;
  endfunction

  function automatic logic [SECT_W-1:0] sectOf(input addr_t a, input bit topBoot);
    logic [UNIT_W-1:0] u;
    u = a[ADDR_W-1 -: UNIT_W];
    if (topBoot) return SECT_W'(NUM_SECT-1) - bottomIdx(~u);
    else         return bottomIdx(u);
  endfunction
endpackage

// File: rtl/flash_ctrl.sv
module flash_ctrl import flash_pkg::*; #(
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 16,
  parameter int WIN_CYC   = 16,
  parameter bit TOP_BOOT  = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrStb,
  input  addr_t               wrAddr,
  input  logic [7:0]          wrData,
  input  logic [NUM_SECT-1:0] protMask,
  input  logic                unprotect,
  output strobe_t             stb
);
  localparam int CNT_A   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_MAX = (CNT_A > WIN_CYC) ? CNT_A : WIN_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam addr_t ADDR_U1 = addr_t'('h555);
  localparam addr_t ADDR_U2 = addr_t'('h2AA);
  localparam addr_t LAST    = addr_t'(DEPTH - 1);

  typedef enum logic [2:0] {S_IDLE, S_PROG, S_EWIN, S_ERASE, S_SUSP, S_SPROG} state_t;
  typedef enum logic [2:0] {C_RD, C_U1, C_U2, C_ER, C_EU1, C_EU2, C_PD} cmd_t;
  typedef enum logic [1:0] {PH_PRE, PH_PULSE, PH_CLR} phase_t;

  state_t              state;
  cmd_t                cmdSt;
  phase_t              phase;
  addr_t               ptr, progAddr;
  logic [7:0]          progData;
  logic [CNT_W-1:0]    cnt;
  logic [NUM_SECT-1:0] sel;

  logic [SECT_W-1:0]   wrSect, ptrSect;
  logic                wrProt, isU1, isU2;
  logic [NUM_SECT-1:0] allUnprot, selBit;

  always_comb begin
    wrSect    = sectOf(wrAddr, TOP_BOOT);
    ptrSect   = sectOf(ptr, TOP_BOOT);
    wrProt    = protMask[wrSect] & ~unprotect;
    allUnprot = ~(protMask & {NUM_SECT{~unprotect}});
    selBit    = NUM_SECT'(1) << wrSect;
    isU1      = (wrAddr == ADDR_U1) && (wrData == 8'hAA);
    isU2      = (wrAddr == ADDR_U2) && (wrData == 8'h55);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      cmdSt    <= C_RD;
      phase    <= PH_PRE;
      ptr      <= '0;
      cnt      <= '0;
      progAddr <= '0;
      progData <= '0;
      sel      <= '0;
    end else begin
      unique case (state)
        S_IDLE, S_SUSP: if (wrStb) begin
          cmdSt <= C_RD;
          unique case (cmdSt)
            C_RD:  if (isU1) cmdSt <= C_U1;
                   else if (state == S_SUSP && wrData == 8'h30) state <= S_ERASE;
            C_U1:  if (isU2) cmdSt <= C_U2;
            C_U2:  if (wrAddr == ADDR_U1) begin
                     if (wrData == 8'hA0) cmdSt <= C_PD;
                     else if (wrData == 8'h80 && state == S_IDLE) cmdSt <= C_ER;
                   end
            C_ER:  if (isU1) cmdSt <= C_EU1;
            C_EU1: if (isU2) cmdSt <= C_EU2;
            C_EU2: if (wrData == 8'h10 && wrAddr == ADDR_U1) begin
                     sel <= allUnprot;
                     if (allUnprot != '0) begin
                       state <= S_ERASE;
                       phase <= PH_PRE;
                       ptr   <= '0;
                     end
                   end else if (wrData == 8'h30) begin
                     sel   <= wrProt ? '0 : selBit;
                     state <= S_EWIN;
                     cnt   <= CNT_W'(WIN_CYC - 1);
                   end
            C_PD:  if (!wrProt && !(state == S_SUSP && sel[wrSect])) begin
                     progAddr <= wrAddr;
                     progData <= wrData;
                     cnt      <= CNT_W'(PROG_CYC - 1);
                     state    <= (state == S_SUSP) ? S_SPROG : S_PROG;
                   end
            default: ;
          endcase
        end
        S_PROG, S_SPROG: begin
          if (cnt == '0) state <= (state == S_SPROG) ? S_SUSP : S_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        S_EWIN: begin
          if (wrStb) begin
            if (wrData == 8'h30) begin
              if (!wrProt) sel[wrSect] <= 1'b1;
              cnt <= CNT_W'(WIN_CYC - 1);
            end else begin
              sel   <= '0;
              state <= S_IDLE;
            end
          end else if (cnt == '0) begin
            if (sel == '0) state <= S_IDLE;
            else begin
              state <= S_ERASE;
              phase <= PH_PRE;
              ptr   <= '0;
            end
          end else cnt <= cnt - 1'b1;
        end
        S_ERASE: begin
          if (wrStb && wrData == 8'hB0) state <= S_SUSP;
          else begin
            unique case (phase)
              PH_PRE: begin
                ptr <= ptr + 1'b1;
                if (ptr == LAST) begin
                  phase <= PH_PULSE;
                  cnt   <= CNT_W'(ERASE_CYC - 1);
                end
              end
              PH_PULSE: begin
                if (cnt == '0) begin
                  phase <= PH_CLR;
                  ptr   <= '0;
                end else cnt <= cnt - 1'b1;
              end
              default: begin
                ptr <= ptr + 1'b1;
                if (ptr == LAST) begin
                  state <= S_IDLE;
                  sel   <= '0;
                end
              end
            endcase
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb           = '0;
    stb.busy      = state inside {S_PROG, S_SPROG, S_EWIN, S_ERASE};
    stb.suspended = (state == S_SUSP);
    stb.eraseSel  = sel;
    stb.pollBit   = (state inside {S_PROG, S_SPROG}) ? ~progData[7] : 1'b0;
    if ((state inside {S_PROG, S_SPROG}) && cnt == '0) begin
      stb.memWe   = 1'b1;
      stb.memAnd  = 1'b1;
      stb.memAddr = progAddr;
      stb.memData = progData;
    end else if (state == S_ERASE && phase != PH_PULSE && sel[ptrSect]) begin
      stb.memWe   = 1'b1;
      stb.memAddr = ptr;
      stb.memData = (phase == PH_PRE) ? 8'h00 : 8'hFF;
    end
  end

  AST_ERASE_IN_SEL: assert property (@(posedge clk) disable iff (!rstN)
    (stb.memWe && !stb.memAnd) |-> sel[sectOf(stb.memAddr, TOP_BOOT)]); // R6
  AST_SUSP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SUSP) |-> !stb.memWe); // R7
  AST_RESUME_GO: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SUSP && cmdSt == C_RD && wrStb && wrData == 8'h30) |=> (state == S_ERASE)); // R7
  AST_LOCKED_PROG: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && cmdSt == C_PD && wrStb && wrProt) |=> (state == S_IDLE)); // R8
endmodule

// File: rtl/flash_data.sv
module flash_data import flash_pkg::*; #(
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdStb,
  input  addr_t      rdAddr,
  input  strobe_t    stb,
  output logic [7:0] dataOut
);
  logic [7:0] mem [DEPTH];
  logic       toggleQ;
  logic       lastStat;
  logic       showStatus;

  always_comb
    showStatus = stb.busy | (stb.suspended & stb.eraseSel[sectOf(rdAddr, TOP_BOOT)]);

  always_ff @(posedge clk) begin
    if (stb.memWe)
      mem[stb.memAddr] <= stb.memAnd ? (mem[stb.memAddr] & stb.memData) : stb.memData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut  <= '0;
      toggleQ  <= 1'b0;
      lastStat <= 1'b0;
    end else if (rdStb) begin
      if (showStatus) begin
        dataOut  <= {stb.pollBit, ~toggleQ, 6'b0};
        toggleQ  <= ~toggleQ;
        lastStat <= 1'b1;
      end else begin
        dataOut  <= mem[rdAddr];
        lastStat <= 1'b0;
      end
    end
  end

  AST_TOGGLE_ALT: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && showStatus && lastStat) |=> (dataOut[6] != $past(dataOut[6]))); // R4
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl import flash_pkg::*; #(
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 16,
  parameter int WIN_CYC   = 16,
  parameter bit TOP_BOOT  = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ceN,
  input  logic                oeN,
  input  logic                weN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [7:0]          dataIn,
  output logic [7:0]          dataOut,
  input  logic                lowSupply,
  input  logic                unprotect,
  input  logic [NUM_SECT-1:0] protMask
);
  logic    weNq, oeNq, wrStb, rdStb;
  strobe_t stb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weNq <= 1'b1;
      oeNq <= 1'b1;
    end else begin
      weNq <= weN;
      oeNq <= oeN;
    end
  end

  always_comb begin
    wrStb = !ceN && !weN && weNq && !lowSupply;
    rdStb = !ceN && !oeN && oeNq;
  end

  flash_ctrl #(
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .WIN_CYC(WIN_CYC), .TOP_BOOT(TOP_BOOT)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrAddr(addr), .wrData(dataIn),
    .protMask(protMask), .unprotect(unprotect), .stb(stb)
  );

  flash_data #(.TOP_BOOT(TOP_BOOT)) i_data (
    .clk(clk), .rstN(rstN), .rdStb(rdStb), .rdAddr(addr), .stb(stb), .dataOut(dataOut)
  );

  AST_LOWVCC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (lowSupply && !stb.busy && !stb.suspended) |=> !stb.busy); // R9
endmodule

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ERASE_WAIT = 4400;

  logic        clk = 1'b0;
  logic        rstN, ceN, oeN, weN, lowSupply, unprotect;
  logic [10:0] addr;
  logic [7:0]  dataIn, dataOut, d1, d2;
  logic [6:0]  protMask;
  int          nChecks = 0;
  int          nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_ctrl i_flash_cmd_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .addr(addr),
    .dataIn(dataIn), .dataOut(dataOut), .lowSupply(lowSupply),
    .unprotect(unprotect), .protMask(protMask)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); ceN = 0; weN = 0; addr = a; dataIn = d;
    @(negedge clk); ceN = 1; weN = 1;
  endtask

  task automatic rd(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk); ceN = 0; oeN = 0; addr = a;
    @(negedge clk); d = dataOut; ceN = 1; oeN = 1;
  endtask

  task automatic unlock();
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55);
  endtask

  task automatic progCmd(input logic [10:0] a, input logic [7:0] d);
    unlock(); wr(11'h555, 8'hA0); wr(a, d);
  endtask

  task automatic erasePrefix();
    unlock(); wr(11'h555, 8'h80); unlock();
  endtask

  task automatic testChipErase();
    erasePrefix(); wr(11'h555, 8'h10);
    rd(11'h000, d1);
    check("R4 erase status", d1 & 8'hBF, 8'h00);
    waitCyc(ERASE_WAIT);
    rd(11'h000, d1); check("R5 chip erase low", d1, 8'hFF);
    rd(11'h3FF, d1); check("R5 chip erase mid", d1, 8'hFF);
    rd(11'h7FF, d1); check("R5 chip erase top", d1, 8'hFF);
  endtask

  task automatic testProgram();
    progCmd(11'h123, 8'hA5);
    rd(11'h123, d1); rd(11'h123, d2);
    check("R4 poll bit7", d1 & 8'h80, 8'h00);
    check("R4 low bits zero", d1 & 8'h3F, 8'h00);
    check("R4 toggle bit6", d2 & 8'h40, ~d1 & 8'h40);
    waitCyc(20);
    rd(11'h123, d1); check("R3 program", d1, 8'hA5);
    rd(11'h123, d2); check("R1 read holds array", d2, 8'hA5);
    progCmd(11'h123, 8'h5F);
    waitCyc(20);
    rd(11'h123, d1); check("R3 and-merge", d1, 8'h05);
  endtask

  task automatic testSequenceBreak();
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h12); wr(11'h555, 8'hA0); wr(11'h200, 8'h00);
    waitCyc(20);
    rd(11'h200, d1); check("R10 broken unlock", d1, 8'hFF);
    unlock(); wr(11'h555, 8'hF0); wr(11'h202, 8'h00);
    waitCyc(20);
    rd(11'h202, d1); check("R10 reset-to-read", d1, 8'hFF);
  endtask

  task automatic testLowSupply();
    lowSupply = 1;
    progCmd(11'h201, 8'h00);
    rd(11'h201, d1); check("R9 no status", d1, 8'hFF);
    waitCyc(20);
    lowSupply = 0;
    rd(11'h201, d1); check("R9 blocked program", d1, 8'hFF);
  endtask

  task automatic testProtect();
    protMask = 7'b0000100;
    progCmd(11'h0C5, 8'h00);
    waitCyc(20);
    rd(11'h0C5, d1); check("R8 locked program", d1, 8'hFF);
    unprotect = 1;
    progCmd(11'h0C6, 8'h0F);
    waitCyc(20);
    unprotect = 0;
    rd(11'h0C6, d1); check("R8 override program", d1, 8'h0F);
  endtask

  task automatic testSectorErase();
    progCmd(11'h07F, 8'h11); waitCyc(12);
    progCmd(11'h080, 8'h22); waitCyc(12);
    progCmd(11'h0BF, 8'h33); waitCyc(12);
    progCmd(11'h100, 8'h44); waitCyc(12);
    erasePrefix(); wr(11'h080, 8'h30); wr(11'h100, 8'h30);
    waitCyc(ERASE_WAIT);
    rd(11'h07F, d1); check("R2 sector0 edge kept", d1, 8'h11);
    rd(11'h080, d1); check("R6 sector1 start", d1, 8'hFF);
    rd(11'h0BF, d1); check("R2 sector1 end", d1, 8'hFF);
    rd(11'h100, d1); check("R6 second sector", d1, 8'hFF);
    rd(11'h0C6, d1); check("R6 unselected kept", d1, 8'h0F);
    erasePrefix(); wr(11'h0C6, 8'h30);
    waitCyc(40);
    rd(11'h0C6, d1); check("R8 locked erase", d1, 8'h0F);
  endtask

  task automatic testWindowCancel();
    progCmd(11'h300, 8'h00); waitCyc(12);
    erasePrefix(); wr(11'h300, 8'h30); wr(11'h000, 8'hF0);
    rd(11'h300, d1); check("R6 cancel read mode", d1, 8'h00);
    waitCyc(40);
    rd(11'h300, d1); check("R6 cancel kept", d1, 8'h00);
  endtask

  task automatic testSuspend();
    erasePrefix(); wr(11'h300, 8'h30);
    waitCyc(60);
    wr(11'h000, 8'hB0);
    rd(11'h07F, d1); check("R7 read other sector", d1, 8'h11);
    rd(11'h300, d1); check("R7 erasing sector status", d1 & 8'hBF, 8'h00);
    progCmd(11'h040, 8'h0F);
    waitCyc(20);
    rd(11'h040, d1); check("R7 program while suspended", d1, 8'h0F);
    rd(11'h301, d1); check("R7 still suspended", d1 & 8'hBF, 8'h00);
    wr(11'h000, 8'h30);
    waitCyc(ERASE_WAIT);
    rd(11'h300, d1); check("R7 resumed erase done", d1, 8'hFF);
    rd(11'h040, d1); check("R7 suspend program kept", d1, 8'h0F);
  endtask

  task automatic testResetAbort();
    progCmd(11'h400, 8'h00); waitCyc(12);
    erasePrefix(); wr(11'h400, 8'h30);
    waitCyc(100);
    rstN = 0; waitCyc(2); rstN = 1;
    rd(11'h400, d1); check("R10 abort keeps byte", d1, 8'h00);
    rd(11'h401, d1); check("R10 abort read mode", d1, 8'hFF);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rstN = 0; ceN = 1; oeN = 1; weN = 1; addr = '0; dataIn = '0;
    lowSupply = 0; unprotect = 0; protMask = '0;
    waitCyc(3);
    check("R1 reset dataOut", dataOut, 8'h00);
    rstN = 1;
    waitCyc(2);
    testChipErase();
    testProgram();
    testSequenceBreak();
    testLowSupply();
    testProtect();
    testSectorErase();
    testWindowCancel();
    testSuspend();
    testResetAbort();
    summary();
    $finish;
  end
endmodule